// File: doc/BRIEF.md
# Video Port Access Spacing Throttle

This block sits beside a CPU that can run faster than the bus its video controller was designed for. It watches the CPU's active-low I/O request, the port address and a mode input. Accesses to the video controller's four ports must be spaced out when the CPU runs in its fast mode. The block keeps a count of clock cycles since the last video-port access ended. If a new video-port access starts before that count reaches a threshold, the block pulls an active-low wait output until the count catches up. All other I/O is left alone, and memory cycles are not seen by the block at all.

The count restarts on the first clock edge that finds the I/O request released after an admitted video-port access. It then climbs by one on every edge and stops at the threshold. The threshold is given in fast-clock cycles, with a default of 54. The count keeps running in native mode, so a switch into fast mode right after a video access is still throttled correctly. In native mode the wait output never goes low.

A small state machine tracks the access. **READY**: the count is saturated and no video access is open. **GAP**: the count is still climbing. **ACCESS**: a video-port access has been admitted and is still in progress. The transitions are: READY→ACCESS and GAP→ACCESS when a video-port request appears. ACCESS→GAP when the I/O request is released, which also restarts the count. GAP→READY when the count reaches the threshold.

Top module: `vio_gap_throttle`

## Requirements
- R1: A port is a video port when address bits [7:0] lie in 98h..9Bh inclusive. Bits above bit 7 are ignored, so 1298h and FF9Bh are video ports and 97h and 9Ch are not.
- R2: After reset the count is saturated and `wait_n` is 1. The first video-port access after reset in fast mode sees no wait.
- R3: The first rising edge that samples `iorq_n` = 1 after an admitted video-port access sets the count to 0. Every other edge adds one to the count, and the count never goes past THRESHOLD.
- R4: If a video-port access starts k edges after the restart edge, it is held for THRESHOLD−k cycles when k < THRESHOLD and for none when k ≥ THRESHOLD. In particular, k = THRESHOLD−1 gives exactly one wait cycle.
- R5: A video-port access that starts in the cycle right after the restart edge is held with `wait_n` = 0 for exactly THRESHOLD cycles. `wait_n` returns to 1 in the cycle the count reaches THRESHOLD.
- R6: When `fast_mode` = 0, `wait_n` stays 1. The count still restarts and runs, so a fast-mode access that follows is spaced from the last native-mode video access.
- R7: An I/O access to a non-video port never drives `wait_n` low and does not restart the count.
- R8: While `iorq_n` = 1, `wait_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iorq_n | input | 1 | Active-low CPU I/O request |
| addr | input | ADDR_W | CPU address bus; only bits [7:0] are decoded |
| fast_mode | input | 1 | 1 = fast CPU mode (throttle active), 0 = native mode |
| wait_n | output | 1 | Active-low wait to the CPU, combinational from the inputs and count |

## Verification
On every cycle the assertions check the following: no wait appears without a request, in native mode, for a non-video port, or once the count is saturated. The count never exceeds the threshold. The count restarts after a released video access and otherwise steps up by one. Only the bench scenarios can show how long each wait lasts: THRESHOLD cycles for a back-to-back access, THRESHOLD−k after k idle cycles, and exactly one cycle at the boundary. They also show that non-video traffic during a gap leaves that length unchanged, and that spacing carries across a switch from native to fast mode.

// File: rtl/vio_gap_pkg.sv
package vio_gap_pkg;

    typedef enum logic [1:0] {
        SP_READY  = 2'd0,
        SP_GAP    = 2'd1,
        SP_ACCESS = 2'd2
    } sp_state_t;

endpackage

// File: rtl/vio_port_match.sv
module vio_port_match #(
    parameter logic [7:0] PORT_BASE      = 8'h98,
    parameter int         PORT_SPAN_LOG2 = 2
) (
    input  logic [7:0] port,
    output logic       hit
);
    localparam logic [7:0] MASK = 8'hFF << PORT_SPAN_LOG2;

    always_comb begin
        hit = ((port & MASK) == (PORT_BASE & MASK));
    end
endmodule

// File: rtl/vio_gap_counter.sv
module vio_gap_counter #(
    parameter int THRESHOLD = 54,
    parameter int CNT_W     = $clog2(THRESHOLD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt,
    output logic             full
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(THRESHOLD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= LIMIT;
        end else if (restart) begin
            cnt <= '0;
        end else if (cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        full = (cnt == LIMIT);
    end
endmodule

// File: rtl/vio_gap_fsm.sv
module vio_gap_fsm
    import vio_gap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic iorq_n,
    input  logic hit,
    input  logic fast_mode,
    input  logic cnt_full,
    output logic restart,
    output logic busy,
    output logic wait_n
);
    sp_state_t state, state_nx;
    logic      video_req;

    always_comb begin
        video_req = !iorq_n && hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SP_READY;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SP_READY:  if (video_req) state_nx = SP_ACCESS;
            SP_GAP: begin
                if (video_req)     state_nx = SP_ACCESS;
                else if (cnt_full) state_nx = SP_READY;
            end
            SP_ACCESS: if (iorq_n) state_nx = SP_GAP;
            default:   state_nx = SP_READY;
        endcase
    end

    always_comb begin
        busy    = (state == SP_ACCESS);
        restart = busy && iorq_n;
        wait_n  = !(fast_mode && !iorq_n && (hit || busy) && !cnt_full);
    end
endmodule

// File: rtl/vio_gap_throttle.sv
module vio_gap_throttle #(
    parameter int         THRESHOLD      = 54,
    parameter int         ADDR_W         = 16,
    parameter logic [7:0] PORT_BASE      = 8'h98,
    parameter int         PORT_SPAN_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iorq_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              fast_mode,
    output logic              wait_n
);
    localparam int CNT_W = $clog2(THRESHOLD + 1);

    logic             port_hit;
    logic             gap_restart;
    logic             gap_full;
    logic             acc_busy;
    logic [CNT_W-1:0] gap_cnt;

    generate
        if (ADDR_W > 8) begin : g_hi_addr
            logic unused_hi;
            assign unused_hi = ^addr[ADDR_W-1:8];
        end
    endgenerate

    vio_port_match #(
        .PORT_BASE      (PORT_BASE),
        .PORT_SPAN_LOG2 (PORT_SPAN_LOG2)
    ) u_match (
        .port (addr[7:0]),
        .hit  (port_hit)
    );

    vio_gap_counter #(
        .THRESHOLD (THRESHOLD),
        .CNT_W     (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (gap_restart),
        .cnt     (gap_cnt),
        .full    (gap_full)
    );

    vio_gap_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .iorq_n    (iorq_n),
        .hit       (port_hit),
        .fast_mode (fast_mode),
        .cnt_full  (gap_full),
        .restart   (gap_restart),
        .busy      (acc_busy),
        .wait_n    (wait_n)
    );
endmodule

// File: rtl/vio_gap_throttle_chk.sv
module vio_gap_throttle_chk #(
    parameter int         THRESHOLD      = 54,
    parameter int         ADDR_W         = 16,
    parameter int         CNT_W          = 6,
    parameter logic [7:0] PORT_BASE      = 8'h98,
    parameter int         PORT_SPAN_LOG2 = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              iorq_n,
    input logic [ADDR_W-1:0] addr,
    input logic              fast_mode,
    input logic              wait_n,
    input logic              busy,
    input logic [CNT_W-1:0]  cnt
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(THRESHOLD);
    localparam int LO = int'(PORT_BASE);
    localparam int HI = LO + (1 << PORT_SPAN_LOG2);

    logic other_port;
    always_comb begin
        other_port = (int'(addr[7:0]) < LO) || (int'(addr[7:0]) >= HI);
    end

    a_r8_idle_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
        iorq_n |-> wait_n);

    a_r6_native_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
        !fast_mode |-> wait_n);

    a_r7_other_port_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (!iorq_n && !busy && other_port) |-> wait_n);

    a_r4_free_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == LIMIT) |-> wait_n);

    a_r3_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIMIT);

    a_r3_restart_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && iorq_n) |=> (cnt == '0));

    a_r3_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        (!(busy && iorq_n) && cnt != LIMIT) |=> (cnt == $past(cnt) + 1'b1));
endmodule

bind vio_gap_throttle vio_gap_throttle_chk #(
    .THRESHOLD      (THRESHOLD),
    .ADDR_W         (ADDR_W),
    .CNT_W          (CNT_W),
    .PORT_BASE      (PORT_BASE),
    .PORT_SPAN_LOG2 (PORT_SPAN_LOG2)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iorq_n    (iorq_n),
    .addr      (addr),
    .fast_mode (fast_mode),
    .wait_n    (wait_n),
    .busy      (acc_busy),
    .cnt       (gap_cnt)
);

// File: tb/tb_vio_gap_throttle.sv
module tb_vio_gap_throttle;
    localparam int CLK_PERIOD = 10;
    localparam int TH = 54;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iorq_n = 1'b1;
    logic [15:0] addr = 16'h0000;
    logic        fast_mode = 1'b1;
    logic        wait_n;

    int  checks = 0;
    int  errors = 0;
    int  m_cnt = TH;
    bit  m_busy = 1'b0;
    bit  finished = 1'b0;

    vio_gap_throttle #(.THRESHOLD(TH), .ADDR_W(16)) dut (
        .clk (clk), .rst_n (rst_n), .iorq_n (iorq_n),
        .addr (addr), .fast_mode (fast_mode), .wait_n (wait_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic bit is_video(input logic [15:0] a);
        return (a[7:0] >= 8'h98) && (a[7:0] <= 8'h9B);
    endfunction

    task automatic check_bit(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s wait_n actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic check_int(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s wait cycles actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic io_n, input logic [15:0] a, input logic fm,
                        input string req, output logic w);
        logic exp;
        @(negedge clk);
        iorq_n = io_n; addr = a; fast_mode = fm;
        #1;
        exp = !(fm && !io_n && (is_video(a) || m_busy) && m_cnt != TH);
        w = wait_n;
        check_bit(w, exp, req);
        @(posedge clk);
        if (m_busy && io_n) begin
            m_busy = 1'b0;
            m_cnt  = 0;
        end else begin
            if (m_cnt < TH) m_cnt++;
            if (!io_n && is_video(a)) m_busy = 1'b1;
        end
    endtask

    task automatic idle(input int n, input logic fm, input string req);
        logic w;
        for (int i = 0; i < n; i++) step(1'b1, 16'h0000, fm, req, w);
    endtask

    task automatic access(input logic [15:0] a, input logic fm, input string req,
                          output int lows);
        logic w;
        int   guard = 0;
        lows = 0;
        do begin
            step(1'b0, a, fm, req, w);
            if (!w) lows++;
            guard++;
        end while (!w && guard < TH + 10);
        step(1'b0, a, fm, req, w);
        step(1'b1, a, fm, "R8", w);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int   lows;
        logic w;
        void'($urandom(32'd9031));

        // R2: reset holds the count saturated, no wait even with a video request
        repeat (2) @(negedge clk);
        iorq_n = 1'b0; addr = 16'h0098; fast_mode = 1'b1;
        #1 check_bit(wait_n, 1'b1, "R2 in reset");
        @(negedge clk);
        iorq_n = 1'b1; rst_n = 1'b1;

        // R2: first access after reset is free
        access(16'h0098, 1'b1, "R2", lows);
        check_int(lows, 0, "R2 first access");

        // R5: back-to-back access held exactly TH cycles
        access(16'h009B, 1'b1, "R5", lows);
        check_int(lows, TH, "R5 back-to-back");

        // R7 and R1: non-video traffic during the gap, neither waited nor restarting
        for (int i = 0; i < 5; i++) begin
            step(1'b0, (i % 2) ? 16'h0097 : 16'h009C, 1'b1, "R7 R1 other port", w);
            check_bit(w, 1'b1, "R7 other port no wait");
            step(1'b1, 16'h0000, 1'b1, "R8", w);
        end
        access(16'h0099, 1'b1, "R7", lows);
        check_int(lows, TH - 10, "R7 count not restarted");

        // R1: upper address bits ignored
        access(16'hFF9A, 1'b1, "R1", lows);
        check_int(lows, TH, "R1 FF9A decoded as video");
        access(16'h1297, 1'b1, "R1", lows);
        check_int(lows, 0, "R1 1297 not video");

        // R4: boundary at TH-1 and TH idle cycles
        idle(TH, 1'b1, "R8");
        access(16'h0098, 1'b1, "R4", lows);
        idle(TH - 1, 1'b1, "R8");
        access(16'h0098, 1'b1, "R4", lows);
        check_int(lows, 1, "R4 k=TH-1");
        idle(TH, 1'b1, "R8");
        access(16'h0098, 1'b1, "R4", lows);
        check_int(lows, 0, "R4 k=TH");
        idle(20, 1'b1, "R8");
        access(16'h0098, 1'b1, "R4 R3", lows);
        check_int(lows, TH - 20, "R4 k=20");

        // R6: native mode never waits, but the count still runs
        access(16'h0099, 1'b0, "R6", lows);
        check_int(lows, 0, "R6 native no wait");
        access(16'h009A, 1'b1, "R6", lows);
        check_int(lows, TH, "R6 spacing kept across mode switch");

        // R3: saturation, long idle then free access
        idle(3 * TH, 1'b1, "R8");
        access(16'h009B, 1'b1, "R3", lows);
        check_int(lows, 0, "R3 saturated");

        // Random mix checked cycle by cycle against the model
        for (int i = 0; i < 6000; i++) begin
            logic        io;
            logic [15:0] a;
            logic        fm;
            int          r;
            if ($urandom_range(0, 80) == 0) idle(TH + 5, 1'b1, "R3 R8");
            io = ($urandom_range(0, 3) == 0);
            r  = $urandom_range(0, 5);
            a  = {8'($urandom), 8'h00};
            if (r < 4)       a[7:0] = 8'h98 + 8'(r);
            else if (r == 4) a[7:0] = 8'h97;
            else             a[7:0] = 8'h9C;
            fm = ($urandom_range(0, 9) != 0);
            step(io, a, fm, "R4 R7 random", w);
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule